// File: doc/BRIEF.md
# Buddy Block Allocator

This block hands out and takes back pieces of a memory region of 2^MAX_ORD bytes. The region starts on a 2^MAX_ORD boundary. Each piece is a power-of-two block with an order between MIN_ORD and MAX_ORD. Free blocks are tracked in one bitmap per order. The region itself is never read or written, and the block returns addresses only.

An allocate request carries a byte count. The count is rounded up to a block order. When that order has no free block, the block takes the lowest-address block of the nearest larger order that has one and halves it, one step per cycle. The lower half is kept and each upper half is marked free. A free request carries a block address and its order. The block then combines the freed block with its partner at the same order, one step per cycle, for as long as the partner is also free. The partner's address differs from the freed block's address in bit `order` only.

Requests use a valid/ready handshake. Every request gets a single-cycle response that carries a fail flag, an address and an order.

Top module: `buddy_alloc`

## Requirements
- R1: After reset, `req_ready` is high, `rsp_valid` is low, and the only free block is the whole region: order MAX_ORD at address 0.
- R2: An allocation of `s` bytes is served at order max(MIN_ORD, ceil(log2 s)). A size of 0 or 1 is served at MIN_ORD.
- R3: An allocation larger than 2^MAX_ORD bytes fails. Every failed response carries address 0 and order 0.
- R4: An allocation takes the smallest order, at or above the needed order, that has a free block. Within that order it takes the free block with the lowest address. Each split keeps the lower half and marks the upper half free at the next order down.
- R5: If no block of the needed order or any larger order is free, the allocation fails and the free state is left unchanged.
- R6: A free (`req_free`=1) merges the block at address A and order i with the block at A XOR 2^i when that block is free at order i. Merging repeats at the next order up. The response reports the final address and order of the merged block.
- R7: Merging stops at order MAX_ORD. Freeing every allocated block brings back a single free block of order MAX_ORD at address 0.
- R8: A free whose order lies outside MIN_ORD..MAX_ORD, or whose address has any of its low `order` bits set, fails and changes nothing.
- R9: `req_ready` is low from the cycle after a request is accepted until its response. `rsp_valid` is high for exactly one cycle per request.
- R10: Measured in clock edges after the accepting edge, the response of a successful allocation comes at 1 + (number of splits) and the response of a valid free comes at 1 + (number of merges). A failed request responds at edge 1.
- R11: The address of a successful allocation is a multiple of 2^`rsp_order`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_free | input | 1 | 1 = free a block, 0 = allocate |
| req_size | input | SIZE_W | Byte count for an allocation |
| req_addr | input | MAX_ORD | Block address for a free |
| req_order | input | clog2(MAX_ORD+1) | Block order for a free |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fail | output | 1 | Request could not be served |
| rsp_addr | output | MAX_ORD | Granted address, or merged address on a free |
| rsp_order | output | clog2(MAX_ORD+1) | Granted order, or merged order on a free |

## Verification
The hardest states to reach are long merge cascades and full exhaustion. A cascade runs through several orders only when the right partners have already been freed in an unlucky order. Exhaustion needs the region split all the way down to the smallest order. To reach both, the bench fills the region with minimum-size blocks until an allocation fails, then frees them in random order. Many of those frees trigger chains of merges, and the last one must bring back the whole region. A long seeded mix of random allocations and frees then leaves the region fragmented in many different ways, and it includes sizes just above each power of two and sizes above the region.

// File: rtl/buddy_pkg.sv
// Shared types for the buddy allocator.
package buddy_pkg;

    // Controller phases: idle, pick a source block, halve it, combine with partner
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIND  = 2'd1,
        ST_SPLIT = 2'd2,
        ST_MERGE = 2'd3
    } bst_e;

endpackage

// File: rtl/lowest_set.sv
// lowest_set: priority encoder returning the index of the lowest set bit.
// Assumes OUT_W is wide enough to hold WIDTH-1; idx is 0 when no bit is set.
module lowest_set #(
    parameter int WIDTH = 8,
    parameter int OUT_W = 3
) (
    input  logic [WIDTH-1:0] vec,
    output logic             any,
    output logic [OUT_W-1:0] idx
);

    // Scan from the top so that the lowest set bit is written last
    always_comb begin
        any = |vec;
        idx = '0;
        for (int b = WIDTH - 1; b >= 0; b--) begin
            if (vec[b]) idx = OUT_W'(b);
        end
    end

endmodule

// File: rtl/size_to_order.sv
// size_to_order: turns a byte count into a block level (order - MIN_ORD).
// Assumes SIZE_W > MAX_ORD so the region size is representable. Counts of
// 0 and 1 map to level 0. too_big flags counts above 2^MAX_ORD.
module size_to_order #(
    parameter int SIZE_W  = 16,
    parameter int MIN_ORD = 5,
    parameter int MAX_ORD = 12,
    parameter int LVL_W   = 3
) (
    input  logic [SIZE_W-1:0] size,
    output logic [LVL_W-1:0]  lvl,
    output logic              too_big
);

    localparam logic [SIZE_W-1:0] REGION = SIZE_W'(1) << MAX_ORD;

    // Smallest order whose block holds the count, found by a downward scan
    always_comb begin
        too_big = size > REGION;
        lvl     = '0;
        for (int o = MAX_ORD; o >= MIN_ORD; o--) begin
            if (size <= (SIZE_W'(1) << o)) lvl = LVL_W'(o - MIN_ORD);
        end
    end

endmodule

// File: rtl/free_bitmaps.sv
// free_bitmaps: one free-bit vector per level. Level k covers blocks of
// order MIN_ORD+k, and has 2^(NUM_ORD-1-k) meaningful slots. Provides
// one write port, one read port and a lowest-free-slot encoder per level.
// Assumes the writer only sets clear bits and clears set bits.
module free_bitmaps #(
    parameter int NUM_ORD = 8,
    parameter int SLOTS   = 128,
    parameter int IDX_W   = 7,
    parameter int LVL_W   = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [LVL_W-1:0]                wr_lvl,
    input  logic [IDX_W-1:0]                wr_idx,
    input  logic                            wr_val,
    input  logic [LVL_W-1:0]                rd_lvl,
    input  logic [IDX_W-1:0]                rd_idx,
    output logic                            rd_bit,
    output logic [NUM_ORD-1:0]              avail,
    output logic [NUM_ORD-1:0][IDX_W-1:0]   low_idx
);

    logic [NUM_ORD-1:0][SLOTS-1:0] map_q;

    // Free-bit storage: reset leaves only the whole region free
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_q                <= '0;
            map_q[NUM_ORD-1][0]  <= 1'b1;
        end else if (wr_en) begin
            map_q[wr_lvl][wr_idx] <= wr_val;
        end
    end

    // Partner lookup for merging
    assign rd_bit = map_q[rd_lvl][rd_idx];

    // Lowest free slot at every level, sized to that level's slot count
    for (genvar k = 0; k < NUM_ORD; k++) begin : g_lvl
        localparam int W = 1 << (NUM_ORD - 1 - k);
        lowest_set #(
            .WIDTH (W),
            .OUT_W (IDX_W)
        ) u_pick (
            .vec (map_q[k][W-1:0]),
            .any (avail[k]),
            .idx (low_idx[k])
        );
    end

    // R6
    set_only_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_val |-> !map_q[wr_lvl][wr_idx]);

    // R4
    clear_only_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wr_val |-> map_q[wr_lvl][wr_idx]);

    // R4
    slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ((int'(wr_idx) >> (NUM_ORD - 1 - int'(wr_lvl))) == 0));

endmodule

// File: rtl/buddy_alloc.sv
// buddy_alloc: power-of-two block allocator for a 2^MAX_ORD byte region.
// An allocation picks a source block in one cycle and then halves it once
// per cycle. A free combines the block with its partner once per cycle.
// Assumes the caller frees only blocks it was granted, each once, and
// with the granted order.
module buddy_alloc
    import buddy_pkg::*;
#(
    parameter int MIN_ORD = 5,
    parameter int MAX_ORD = 12,
    parameter int SIZE_W  = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             req_valid,
    output logic                             req_ready,
    input  logic                             req_free,
    input  logic [SIZE_W-1:0]                req_size,
    input  logic [MAX_ORD-1:0]               req_addr,
    input  logic [$clog2(MAX_ORD+1)-1:0]     req_order,
    output logic                             rsp_valid,
    output logic                             rsp_fail,
    output logic [MAX_ORD-1:0]               rsp_addr,
    output logic [$clog2(MAX_ORD+1)-1:0]     rsp_order
);

    localparam int ADDR_W  = MAX_ORD;
    localparam int ORD_W   = $clog2(MAX_ORD + 1);
    localparam int NUM_ORD = MAX_ORD - MIN_ORD + 1;
    localparam int LVL_W   = (NUM_ORD > 1) ? $clog2(NUM_ORD) : 1;
    localparam int IDX_W   = (NUM_ORD > 1) ? NUM_ORD - 1 : 1;
    localparam int SLOTS   = 1 << (NUM_ORD - 1);
    localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(NUM_ORD - 1);

    // Slot number of an address at a level
    function automatic logic [IDX_W-1:0] slot_of(input logic [ADDR_W-1:0] a,
                                                 input logic [LVL_W-1:0] l);
        return IDX_W'(a >> (int'(l) + MIN_ORD));
    endfunction

    // Address of a slot at a level
    function automatic logic [ADDR_W-1:0] base_of(input logic [IDX_W-1:0] i,
                                                  input logic [LVL_W-1:0] l);
        return ADDR_W'(i) << (int'(l) + MIN_ORD);
    endfunction

    // Absolute order of a level
    function automatic logic [ORD_W-1:0] ord_of(input logic [LVL_W-1:0] l);
        return ORD_W'(int'(l) + MIN_ORD);
    endfunction

    bst_e                           state_q;
    logic [LVL_W-1:0]               need_q;
    logic                           big_q;
    logic                           bad_q;
    logic [LVL_W-1:0]               cur_lvl_q;
    logic [ADDR_W-1:0]              cur_addr_q;
    logic                           rsp_valid_q;
    logic                           rsp_fail_q;
    logic [ADDR_W-1:0]              rsp_addr_q;
    logic [ORD_W-1:0]               rsp_order_q;

    logic [LVL_W-1:0]               size_lvl;
    logic                           size_big;
    logic                           wr_en;
    logic [LVL_W-1:0]               wr_lvl;
    logic [IDX_W-1:0]               wr_idx;
    logic                           wr_val;
    logic                           rd_bit;
    logic [NUM_ORD-1:0]             avail;
    logic [NUM_ORD-1:0][IDX_W-1:0]  low_idx;
    logic                           found;
    logic [LVL_W-1:0]               pick;
    logic                           accept;
    logic                           order_ok;
    logic                           free_bad;
    logic [LVL_W-1:0]               req_lvl;
    logic [ADDR_W-1:0]              low_mask;
    logic [LVL_W-1:0]               sp_lvl;
    logic [IDX_W-1:0]               sp_idx;
    logic [IDX_W-1:0]               own_idx;
    logic [IDX_W-1:0]               bud_idx;
    logic                           can_merge;

    size_to_order #(
        .SIZE_W  (SIZE_W),
        .MIN_ORD (MIN_ORD),
        .MAX_ORD (MAX_ORD),
        .LVL_W   (LVL_W)
    ) u_size (
        .size    (req_size),
        .lvl     (size_lvl),
        .too_big (size_big)
    );

    free_bitmaps #(
        .NUM_ORD (NUM_ORD),
        .SLOTS   (SLOTS),
        .IDX_W   (IDX_W),
        .LVL_W   (LVL_W)
    ) u_maps (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_lvl  (wr_lvl),
        .wr_idx  (wr_idx),
        .wr_val  (wr_val),
        .rd_lvl  (cur_lvl_q),
        .rd_idx  (bud_idx),
        .rd_bit  (rd_bit),
        .avail   (avail),
        .low_idx (low_idx)
    );

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;

    // Validity of an incoming free: order in range and address aligned to it
    always_comb begin
        order_ok = (int'(req_order) >= MIN_ORD) && (int'(req_order) <= MAX_ORD);
        low_mask = ~({ADDR_W{1'b1}} << req_order);
        free_bad = !order_ok || (|(req_addr & low_mask));
        req_lvl  = LVL_W'(int'(req_order) - MIN_ORD);
    end

    // Smallest level at or above the needed one that holds a free block
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int k = NUM_ORD - 1; k >= 0; k--) begin
            if (avail[k] && (LVL_W'(k) >= need_q)) begin
                found = 1'b1;
                pick  = LVL_W'(k);
            end
        end
    end

    // Slot arithmetic for the split and merge steps
    always_comb begin
        sp_lvl    = cur_lvl_q - LVL_W'(1);
        sp_idx    = slot_of(cur_addr_q, sp_lvl) ^ IDX_W'(1);
        own_idx   = slot_of(cur_addr_q, cur_lvl_q);
        bud_idx   = own_idx ^ IDX_W'(1);
        can_merge = (state_q == ST_MERGE) && !bad_q &&
                    (cur_lvl_q != TOP_LVL) && rd_bit;
    end

    // Bitmap write selection for the current phase
    always_comb begin
        wr_en  = 1'b0;
        wr_val = 1'b0;
        wr_lvl = '0;
        wr_idx = '0;
        case (state_q)
            ST_FIND: begin
                if (!big_q && found) begin
                    wr_en  = 1'b1;
                    wr_lvl = pick;
                    wr_idx = low_idx[pick];
                end
            end
            ST_SPLIT: begin
                wr_en  = 1'b1;
                wr_val = 1'b1;
                wr_lvl = sp_lvl;
                wr_idx = sp_idx;
            end
            ST_MERGE: begin
                if (!bad_q) begin
                    wr_en  = 1'b1;
                    wr_lvl = cur_lvl_q;
                    wr_val = !can_merge;
                    wr_idx = can_merge ? bud_idx : own_idx;
                end
            end
            default: ;
        endcase
    end

    // Controller sequencing and registered response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            need_q      <= '0;
            big_q       <= 1'b0;
            bad_q       <= 1'b0;
            cur_lvl_q   <= '0;
            cur_addr_q  <= '0;
            rsp_valid_q <= 1'b0;
            rsp_fail_q  <= 1'b0;
            rsp_addr_q  <= '0;
            rsp_order_q <= '0;
        end else begin
            rsp_valid_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (req_free) begin
                            state_q    <= ST_MERGE;
                            cur_addr_q <= req_addr;
                            cur_lvl_q  <= req_lvl;
                            bad_q      <= free_bad;
                        end else begin
                            state_q <= ST_FIND;
                            need_q  <= size_lvl;
                            big_q   <= size_big;
                        end
                    end
                end
                ST_FIND: begin
                    if (big_q || !found) begin
                        state_q     <= ST_IDLE;
                        rsp_valid_q <= 1'b1;
                        rsp_fail_q  <= 1'b1;
                        rsp_addr_q  <= '0;
                        rsp_order_q <= '0;
                    end else if (pick == need_q) begin
                        state_q     <= ST_IDLE;
                        rsp_valid_q <= 1'b1;
                        rsp_fail_q  <= 1'b0;
                        rsp_addr_q  <= base_of(low_idx[pick], pick);
                        rsp_order_q <= ord_of(pick);
                    end else begin
                        state_q    <= ST_SPLIT;
                        cur_lvl_q  <= pick;
                        cur_addr_q <= base_of(low_idx[pick], pick);
                    end
                end
                ST_SPLIT: begin
                    cur_lvl_q <= sp_lvl;
                    if (sp_lvl == need_q) begin
                        state_q     <= ST_IDLE;
                        rsp_valid_q <= 1'b1;
                        rsp_fail_q  <= 1'b0;
                        rsp_addr_q  <= cur_addr_q;
                        rsp_order_q <= ord_of(sp_lvl);
                    end
                end
                ST_MERGE: begin
                    if (bad_q) begin
                        state_q     <= ST_IDLE;
                        rsp_valid_q <= 1'b1;
                        rsp_fail_q  <= 1'b1;
                        rsp_addr_q  <= '0;
                        rsp_order_q <= '0;
                    end else if (can_merge) begin
                        cur_addr_q <= cur_addr_q &
                                      ~(ADDR_W'(1) << (int'(cur_lvl_q) + MIN_ORD));
                        cur_lvl_q  <= cur_lvl_q + LVL_W'(1);
                    end else begin
                        state_q     <= ST_IDLE;
                        rsp_valid_q <= 1'b1;
                        rsp_fail_q  <= 1'b0;
                        rsp_addr_q  <= cur_addr_q;
                        rsp_order_q <= ord_of(cur_lvl_q);
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_fail  = rsp_fail_q;
    assign rsp_addr  = rsp_addr_q;
    assign rsp_order = rsp_order_q;

    // R9
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    // R9
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R11
    alloc_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_fail |-> ((rsp_addr & ~({ADDR_W{1'b1}} << rsp_order)) == '0));

    // R3
    fail_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fail |-> (rsp_addr == '0) && (rsp_order == '0));

    // R4
    split_above_need_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_SPLIT |-> cur_lvl_q > need_q);

    // R7
    order_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_fail |->
            (int'(rsp_order) >= MIN_ORD) && (int'(rsp_order) <= MAX_ORD));

endmodule

// File: tb/buddy_alloc_bench.sv
// Self-checking bench for buddy_alloc against a reference model written
// from the requirements.
module buddy_alloc_bench;

    localparam int LO = 5;
    localparam int HI = 12;
    localparam int NO = HI - LO + 1;
    localparam int SW = 16;
    localparam int NSLOT = 1 << (NO - 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_free = 1'b0;
    logic [SW-1:0] req_size = '0;
    logic [HI-1:0] req_addr = '0;
    logic [3:0]    req_order = '0;
    logic          rsp_valid;
    logic          rsp_fail;
    logic [HI-1:0] rsp_addr;
    logic [3:0]    rsp_order;

    int n_chk = 0;
    int n_bad = 0;
    bit fm [NO][NSLOT];
    int al_addr [512];
    int al_ord  [512];
    int al_n = 0;

    always #4 clk = ~clk;

    buddy_alloc #(.MIN_ORD(LO), .MAX_ORD(HI), .SIZE_W(SW)) u_buddy_alloc (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_free  (req_free),
        .req_size  (req_size),
        .req_addr  (req_addr),
        .req_order (req_order),
        .rsp_valid (rsp_valid),
        .rsp_fail  (rsp_fail),
        .rsp_addr  (rsp_addr),
        .rsp_order (rsp_order)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic model_reset();
        for (int l = 0; l < NO; l++)
            for (int s = 0; s < NSLOT; s++) fm[l][s] = 1'b0;
        fm[NO-1][0] = 1'b1;
    endtask

    function automatic int need_of(input int size);
        int o;
        if (size > (1 << HI)) return -1;
        o = LO;
        while ((1 << o) < size) o++;
        return o;
    endfunction

    task automatic model_alloc(input int size, output bit f, output int a,
                               output int o, output int lat);
        int nd, j, idx;
        bit hit;
        nd = need_of(size);
        f = 1'b1; a = 0; o = 0; lat = 1; hit = 1'b0; j = 0; idx = 0;
        if (nd < 0) return;
        for (int jj = nd; jj <= HI && !hit; jj++)
            for (int s = 0; s < (1 << (HI - jj)) && !hit; s++)
                if (fm[jj-LO][s]) begin hit = 1'b1; j = jj; idx = s; end
        if (!hit) return;
        fm[j-LO][idx] = 1'b0;
        a = idx << j;
        lat = 1 + (j - nd);
        while (j > nd) begin
            j--;
            fm[j-LO][(a >> j) ^ 1] = 1'b1;
        end
        f = 1'b0;
        o = nd;
    endtask

    task automatic model_free(input int a_in, input int o_in, output bit f,
                              output int ra, output int ro, output int lat);
        int a, o;
        a = a_in; o = o_in;
        f = 1'b1; ra = 0; ro = 0; lat = 1;
        if (o < LO || o > HI || (a & ((1 << o) - 1)) != 0) return;
        while (o < HI && fm[o-LO][(a >> o) ^ 1]) begin
            fm[o-LO][(a >> o) ^ 1] = 1'b0;
            a = a & ~(1 << o);
            o++;
            lat++;
        end
        fm[o-LO][a >> o] = 1'b1;
        f = 1'b0; ra = a; ro = o;
    endtask

    // Drive one request starting at a negedge; returns the response and edge count
    task automatic dut_req(input bit fr, input int size, input int addr, input int ord,
                           output bit gf, output int ga, output int go, output int lat);
        bit seen;
        chk(req_ready == 1'b1, "R9 ready before request", int'(req_ready), 1);
        req_valid = 1'b1;
        req_free  = fr;
        req_size  = SW'(size);
        req_addr  = HI'(addr);
        req_order = 4'(ord);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R9 busy after accept", int'(req_ready), 0);
        lat = 0; seen = 1'b0;
        for (int w = 0; w < 64 && !seen; w++) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (rsp_valid) seen = 1'b1;
            else chk(req_ready == 1'b0, "R9 busy while working", int'(req_ready), 0);
        end
        chk(seen, "R9 response arrived", int'(seen), 1);
        gf = rsp_fail; ga = int'(rsp_addr); go = int'(rsp_order);
        @(posedge clk);
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R9 one-cycle response", int'(rsp_valid), 0);
    endtask

    task automatic do_alloc(input int size, input string tag);
        bit ef, gf; int ea, eo, el, ga, go, gl;
        model_alloc(size, ef, ea, eo, el);
        dut_req(1'b0, size, 0, 0, gf, ga, go, gl);
        chk(gf == ef, {tag, " R5 fail flag"}, int'(gf), int'(ef));
        chk(ga == ea, {tag, " R4 address"}, ga, ea);
        chk(go == eo, {tag, " R2 order"}, go, eo);
        chk(gl == el, {tag, " R10 latency"}, gl, el);
        if (!gf) begin
            chk((ga % (1 << go)) == 0, {tag, " R11 alignment"}, ga, 0);
            al_addr[al_n] = ga;
            al_ord[al_n]  = go;
            al_n++;
        end
    endtask

    task automatic do_free(input int addr, input int ord, input string tag);
        bit ef, gf; int ea, eo, el, ga, go, gl;
        model_free(addr, ord, ef, ea, eo, el);
        dut_req(1'b1, 0, addr, ord, gf, ga, go, gl);
        chk(gf == ef, {tag, " R8 fail flag"}, int'(gf), int'(ef));
        chk(ga == ea, {tag, " R6 merged address"}, ga, ea);
        chk(go == eo, {tag, " R6 merged order"}, go, eo);
        chk(gl == el, {tag, " R10 latency"}, gl, el);
    endtask

    task automatic free_slot(input int k, input string tag);
        int a, o;
        a = al_addr[k]; o = al_ord[k];
        al_addr[k] = al_addr[al_n-1];
        al_ord[k]  = al_ord[al_n-1];
        al_n--;
        do_free(a, o, tag);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle and ready after reset
        chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
        chk(rsp_valid == 1'b0, "R1 no response after reset", int'(rsp_valid), 0);

        // R1: whole region available at address 0
        do_alloc(1 << HI, "R1 whole region");
        do_alloc(1, "R5 region taken");
        free_slot(0, "R7 whole region back");

        // R3: oversized requests
        do_alloc((1 << HI) + 1, "R3 one over region");
        do_alloc(65535, "R3 largest count");

        // R2/R4/R10: deepest split then rounding of small counts
        do_alloc(0, "R2 zero bytes");
        do_alloc(1, "R2 one byte");
        do_alloc(33, "R2 just over minimum");
        do_alloc(64, "R2 exact power");
        do_alloc(65, "R2 just over power");
        do_alloc(2048, "R4 half region");

        // R8: malformed frees leave the state untouched
        do_free(0, LO - 1, "R8 order too small");
        do_free(0, HI + 1, "R8 order too large");
        do_free(32, LO + 1, "R8 misaligned");
        do_alloc(32, "R8 state intact");

        // R6/R7: release everything in random order
        while (al_n > 0) free_slot(int'($urandom_range(0, al_n - 1)), "R6 drain");
        do_alloc(1 << HI, "R7 coalesced region");
        free_slot(0, "R7 release region");

        // R5: exhaust with minimum blocks
        for (int i = 0; i < (1 << (HI - LO)); i++) do_alloc(32, "R4 fill");
        do_alloc(1, "R5 exhausted");
        while (al_n > 0) free_slot(int'($urandom_range(0, al_n - 1)), "R6 cascade");
        do_alloc(1 << HI, "R7 after cascade");
        free_slot(0, "R7 release again");

        // Random mix
        for (int i = 0; i < 700; i++) begin
            if (al_n > 0 && ($urandom_range(0, 99) < 45)) begin
                free_slot(int'($urandom_range(0, al_n - 1)), "R6 random free");
            end else begin
                int sz;
                case ($urandom_range(0, 3))
                    0: sz = int'($urandom_range(0, 64));
                    1: sz = int'($urandom_range(0, 600));
                    2: sz = (1 << $urandom_range(LO, HI)) + int'($urandom_range(0, 1));
                    default: sz = int'($urandom_range(0, 5000));
                endcase
                do_alloc(sz, "R4 random alloc");
            end
        end
        while (al_n > 0) free_slot(int'($urandom_range(0, al_n - 1)), "R7 final drain");
        do_alloc(1 << HI, "R7 final region");

        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog R9 actual=%0d expected=%0d", 0, 1);
        finish_run();
    end

endmodule